// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Shifter

This block sits on the slave side of a serial link. It answers a reset pulse by sending out a fixed identification word. The host first selects the slave by pulling the active-low chip-select low. It then pulses the reset request high and back low. From that point the slave shifts the word out bit by bit on an open-drain data line, one bit per serial clock cycle. The word is a build-time parameter and takes the place of a constant that would otherwise be fixed in silicon.

The block drives the open-drain line through a value/enable pair: `sda_oe` high means the block owns the line, and `sda_o` is the level it presents. Chip-select, reset request, serial clock and the write-busy flag arrive asynchronously. They are synchronized to a fast system clock, and all edge detection happens in that domain. The sequence can end in two ways, and each gives a one-cycle pulse:
- a normal finish after the last bit;
- an abort when chip-select rises.

A reset pulse that arrives while a nonvolatile write is busy, or while the slave is deselected, is ignored.

Top module: `atr_shifter`

## Requirements
- R1: After system reset, `sda_oe`, `atr_done` and `atr_abort` are 0 and `sda_o` is 1.
- R2: A rising then falling edge on `atr_req` while `cs_n` is low and `wr_busy` is low starts the sequence. The line stays released while `atr_req` is high. After `atr_req` falls, `sda_oe` goes to 1 and bit 0 of the word appears on `sda_o`.
- R3: Each falling edge of `sclk` advances the output to the next bit. A rising edge of `sclk` leaves `sda_o` unchanged.
- R4: The word goes out least significant bit first: after k falling edges of `sclk`, `sda_o` equals bit k of the word.
- R5: The falling `sclk` edge that follows the last bit (edge number WORD_W counted from the start) releases the line. `atr_done` is high for exactly one system clock cycle, and the block returns to standby.
- R6: If `cs_n` goes high while the sequence is armed or shifting, the line is released and `atr_abort` pulses for one cycle. The block then returns to standby, where later `sclk` edges drive nothing until a new reset pulse arrives.
- R7: A reset pulse that begins while `wr_busy` is high is ignored: the line stays released, even across later `sclk` edges.
- R8: A reset pulse while `cs_n` is high is ignored.
- R9: Whenever `sda_oe` is 0, `sda_o` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| atr_req | input | 1 | Reset request pulse from host (asynchronous) |
| sclk | input | 1 | Serial clock from host (asynchronous) |
| wr_busy | input | 1 | High while an internal nonvolatile write runs |
| sda_o | output | 1 | Level presented on the data line when enabled |
| sda_oe | output | 1 | Data line drive enable (open-drain ownership) |
| atr_done | output | 1 | One-cycle pulse when the whole word has been sent |
| atr_abort | output | 1 | One-cycle pulse when chip-select aborts a sequence |

## Verification
The bench builds the block with the default 32-bit width, two synchronizer stages and an asymmetric word pattern. With that pattern, a swapped bit order or an off-by-one bit index shows up in the very first positions. Because the word is short, the bench can read the whole word several times and abort at every one of the 32 bit positions. This covers all counter values that the chip-select exit can interrupt. The busy and deselected cases are then each followed by serial clock edges, which shows that no sequence was started quietly.

// File: rtl/atr_pkg.sv
package atr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } atr_state_e;
endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
    parameter int            W      = 4,
    parameter int            STAGES = 2,
    parameter logic [W-1:0]  RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain_q[g] <= RST_V;
                else if (g == 0)
                    chain_q[g] <= async_i;
                else
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/atr_edge.sv
module atr_edge #(
    parameter logic RST_V = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb prev_d = sig_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_V;
        else        prev_q <= prev_d;
    end

    assign rise_o = sig_i & ~prev_q;
    assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/atr_core.sv
module atr_core
    import atr_pkg::*;
#(
    parameter int               WORD_W   = 32,
    parameter logic [WORD_W-1:0] ATR_WORD = '0,
    parameter int               IDX_W    = $clog2(WORD_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic busy_s,
    input  logic req_rise,
    input  logic req_fall,
    input  logic sclk_fall,
    output logic sda_o,
    output logic sda_oe,
    output logic done_o,
    output logic abort_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    typedef struct packed {
        atr_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             sda;
        logic             oe;
        logic             done;
        logic             abort;
    } core_t;

    core_t d, q;
    logic [IDX_W-1:0] idx_inc;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.abort = 1'b0;
        idx_inc = q.idx + IDX_W'(1);
        unique case (q.state)
            ST_IDLE: begin
                if (!cs_n_s && req_rise && !busy_s)
                    d.state = ST_ARMED;
            end
            ST_ARMED: begin
                if (cs_n_s) begin
                    d.state = ST_IDLE;
                    d.abort = 1'b1;
                end else if (req_fall) begin
                    d.state = ST_SHIFT;
                    d.idx   = '0;
                    d.oe    = 1'b1;
                    d.sda   = ATR_WORD[0];
                end
            end
            ST_SHIFT: begin
                if (cs_n_s) begin
                    d.state = ST_IDLE;
                    d.oe    = 1'b0;
                    d.sda   = 1'b1;
                    d.abort = 1'b1;
                end else if (sclk_fall) begin
                    if (q.idx == LAST_IDX) begin
                        d.state = ST_IDLE;
                        d.oe    = 1'b0;
                        d.sda   = 1'b1;
                        d.done  = 1'b1;
                    end else begin
                        d.idx = idx_inc;
                        d.sda = ATR_WORD[idx_inc];
                    end
                end
            end
            default: begin
                d.state = ST_IDLE;
                d.oe    = 1'b0;
                d.sda   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.idx   <= '0;
            q.sda   <= 1'b1;
            q.oe    <= 1'b0;
            q.done  <= 1'b0;
            q.abort <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_o   = q.sda;
    assign sda_oe  = q.oe;
    assign done_o  = q.done;
    assign abort_o = q.abort;

    // R5: the finish pulse lasts one cycle and leaves the line released
    p_done_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_release_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !sda_oe);
    // R6: deselect during an active sequence forces standby on the next cycle
    p_abort_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && q.state != ST_IDLE) |=> (q.state == ST_IDLE && abort_o));
    // R7: a reset request seen while busy never arms the sequence
    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && busy_s) |=> q.state != ST_ARMED);
    // R9: a released line carries the idle level
    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_oe |-> sda_o);
    // R2: the line is only taken over from the armed state
    p_drive_from_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(q.state == ST_ARMED));
endmodule

// File: rtl/atr_shifter.sv
module atr_shifter #(
    parameter int                WORD_W      = 32,
    parameter logic [WORD_W-1:0] ATR_WORD    = 32'h3B02_5A81,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic atr_req,
    input  logic sclk,
    input  logic wr_busy,
    output logic sda_o,
    output logic sda_oe,
    output logic atr_done,
    output logic atr_abort
);
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int N_IN  = 4;
    // bit order: {wr_busy, sclk, atr_req, cs_n}; chip-select idles deselected
    localparam logic [N_IN-1:0] SYNC_RST = 4'b0001;

    logic [N_IN-1:0] raw_in, sync_in;
    logic req_rise, req_fall, sclk_rise, sclk_fall;

    assign raw_in = {wr_busy, sclk, atr_req, cs_n};

    atr_sync #(.W(N_IN), .STAGES(SYNC_STAGES), .RST_V(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    atr_edge #(.RST_V(1'b0)) u_req_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sync_in[1]),
        .rise_o (req_rise),
        .fall_o (req_fall)
    );

    atr_edge #(.RST_V(1'b0)) u_sclk_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sync_in[2]),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    atr_core #(.WORD_W(WORD_W), .ATR_WORD(ATR_WORD), .IDX_W(IDX_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (sync_in[0]),
        .busy_s    (sync_in[3]),
        .req_rise  (req_rise),
        .req_fall  (req_fall),
        .sclk_fall (sclk_fall),
        .sda_o     (sda_o),
        .sda_oe    (sda_oe),
        .done_o    (atr_done),
        .abort_o   (atr_abort)
    );

    // R3: a rising serial clock edge never moves the presented bit
    p_rise_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && sda_oe && !sync_in[0]) |=> $stable(sda_o));
    // R5/R6: finish and abort never coincide
    p_done_abort_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(atr_done && atr_abort));
endmodule

// File: tb/sim_atr_shifter.sv
`timescale 1ns/1ps
module sim_atr_shifter;
    localparam int          W    = 32;
    localparam logic [31:0] WORD = 32'hA5C3_0F96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, atr_req = 1'b0, sclk = 1'b0, wr_busy = 1'b0;
    logic sda_o, sda_oe, atr_done, atr_abort;

    int vectors = 0, fails = 0;
    int done_cnt = 0, abort_cnt = 0, long_done = 0, bad_idle = 0;
    logic done_prev = 1'b0;

    always #4 clk = ~clk;

    atr_shifter #(.WORD_W(W), .ATR_WORD(WORD), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .atr_req(atr_req),
        .sclk(sclk), .wr_busy(wr_busy), .sda_o(sda_o), .sda_oe(sda_oe),
        .atr_done(atr_done), .atr_abort(atr_abort)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (atr_done) done_cnt++;
            if (atr_abort) abort_cnt++;
            if (atr_done && done_prev) long_done++;
            if (!sda_oe && !sda_o) bad_idle++;
        end
        done_prev <= atr_done;
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic start_seq();
        cs_n = 1'b0; wt(6);
        atr_req = 1'b1; wt(6);
        chk("R2 released while req high", int'(sda_oe), 0);
        atr_req = 1'b0; wt(6);
    endtask

    task automatic sclk_cycle();
        sclk = 1'b1; wt(6);
        sclk = 1'b0; wt(6);
    endtask

    task automatic full_read();
        int d0;
        d0 = done_cnt;
        start_seq();
        chk("R2 drive after req falls", int'(sda_oe), 1);
        chk("R4 bit0", int'(sda_o), int'(WORD[0]));
        for (int i = 1; i < W; i++) begin
            sclk = 1'b1; wt(6);
            chk("R3 rise holds bit", int'(sda_o), int'(WORD[i-1]));
            sclk = 1'b0; wt(6);
            chk("R4 bit", int'(sda_o), int'(WORD[i]));
        end
        chk("R5 still driving last bit", int'(sda_oe), 1);
        sclk_cycle();
        chk("R5 released after last", int'(sda_oe), 0);
        chk("R5 one done pulse", done_cnt - d0, 1);
        sclk_cycle();
        chk("R5 standby after done", int'(sda_oe), 0);
        cs_n = 1'b1; wt(6);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wt(3);
        chk("R1 oe", int'(sda_oe), 0);
        chk("R1 done", int'(atr_done), 0);
        chk("R1 abort", int'(atr_abort), 0);
        chk("R1 sda idle", int'(sda_o), 1);
        rst_n = 1'b1; wt(4);

        full_read();
        full_read();

        for (int p = 0; p < W; p++) begin
            int a0;
            a0 = abort_cnt;
            start_seq();
            for (int k = 0; k < p; k++) sclk_cycle();
            chk("R4 bit before abort", int'(sda_o), int'(WORD[p]));
            cs_n = 1'b1; wt(6);
            chk("R6 released on deselect", int'(sda_oe), 0);
            chk("R6 abort pulse", abort_cnt - a0, 1);
            cs_n = 1'b0; wt(6);
            sclk_cycle(); sclk_cycle();
            chk("R6 standby ignores sclk", int'(sda_oe), 0);
            cs_n = 1'b1; wt(6);
        end

        wr_busy = 1'b1; wt(6);
        start_seq();
        chk("R7 busy blocks start", int'(sda_oe), 0);
        sclk_cycle();
        chk("R7 busy sclk", int'(sda_oe), 0);
        wr_busy = 1'b0; wt(6);
        sclk_cycle();
        chk("R7 not deferred", int'(sda_oe), 0);
        cs_n = 1'b1; wt(6);

        atr_req = 1'b1; wt(6);
        atr_req = 1'b0; wt(6);
        cs_n = 1'b0; wt(6);
        chk("R8 deselected pulse ignored", int'(sda_oe), 0);
        sclk_cycle();
        chk("R8 sclk after ignored pulse", int'(sda_oe), 0);
        cs_n = 1'b1; wt(6);

        full_read();

        chk("R5 done never two cycles", long_done, 0);
        chk("R9 idle level", bad_idle, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule